// File: doc/BRIEF.md
# Sum-Addressed Word-Line Decoder

This block selects one row of a memory array whose index is the sum of a base value and an offset, without ever forming that sum with a carry-propagate adder. Every row holds its own constant row number. It folds the base, the offset and the inverted row number into carry-save form, one full adder per bit. The row fires when the sum bits and the carry bits, shifted up one place, are exact complements. That is the case only when base plus offset plus the inverted row number is all ones, which means the sum equals the row number modulo 2^IDX_W. The full width of the index is therefore combined once, inside the decoder, and not twice (once in an adder, once in a decoder).

The block is used ahead of an array's word-line drivers when the row index comes straight out of an address add. An optional output register (parameter REG_OUT) holds the word lines for one clock to help with timing studies. Without it the block is purely combinational from the operands to the lines.

Top module: `sad_decoder`

## Requirements
- R1: Word line L (bit L of `wl_o`, bit 0 being row zero) is high exactly when (`base_i` + `offset_i`) modulo 2^IDX_W equals L.
- R2: For every operand pair, exactly one bit of `wl_o` is high (outside reset when REG_OUT is 1).
- R3: The carry out of the top index bit is discarded: the sum wraps, so for example all ones plus one selects line 0, and all ones plus all ones selects line 2^IDX_W-2.
- R4: The output vector has 2^IDX_W bits, and the selected bit position is the binary value of the wrapped sum, for every IDX_W from 1 to 12.
- R5: With REG_OUT=1 the lines change on the rising clock edge after the operands change, and hold their value between edges. With REG_OUT=0 they follow the operands in the same cycle.
- R6: With REG_OUT=1, an active-low `rst_n` clears every word line to 0 at once, and the lines stay 0 while reset is held, whatever the operands.
- R7: Swapping base and offset selects the same line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register and the checks |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_i | input | IDX_W | Base register part of the row index |
| offset_i | input | IDX_W | Offset added to the base |
| wl_o | output | 2**IDX_W | One-hot word lines, bit L for row L |

## Verification
The bench builds the decoder with IDX_W=6 and REG_OUT=1. At that width all 4096 base/offset pairs fit in a short run, so every row's carry-save match is tried against every operand pair that could fire it, including all wrap-around cases. The registered variant also brings the one-edge latency, the hold between edges and the reset clear within reach. The same row and match logic serves the combinational variant.

// File: rtl/sad_pkg.sv
package sad_pkg;

   localparam int MAX_IDX_W = 12;

   // carry output of one full adder
   function automatic logic maj3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

   // sum output of one full adder
   function automatic logic xor3(input logic a, input logic b, input logic c);
      return a ^ b ^ c;
   endfunction

endpackage

// File: rtl/sad_row.sv
module sad_row
   import sad_pkg::*;
#(
   parameter int IDX_W = 11,
   parameter int ROW   = 0
) (
   input  logic [IDX_W-1:0] base_i,
   input  logic [IDX_W-1:0] offset_i,
   output logic             hit_o
);

   localparam logic [IDX_W-1:0] ROW_BITS = IDX_W'(ROW);
   localparam logic [IDX_W-1:0] ROW_INV  = ~ROW_BITS;

   logic [IDX_W-1:0] sum_v;
   logic [IDX_W:0]   cry_v;   // cry_v[i] has weight 2^i; cry_v[IDX_W] is dropped
   logic [IDX_W-1:0] pair_ok;

   assign cry_v[0] = 1'b0;

   for (genvar b = 0; b < IDX_W; b++) begin : g_bit
      assign sum_v[b]   = xor3(base_i[b], offset_i[b], ROW_INV[b]);
      assign cry_v[b+1] = maj3(base_i[b], offset_i[b], ROW_INV[b]);
      assign pair_ok[b] = sum_v[b] ^ cry_v[b];
   end

   // all ones in carry-save form with no carries left: the row matches
   assign hit_o = &pair_ok;

endmodule

// File: rtl/sad_out_stage.sv
module sad_out_stage #(
   parameter int WIDTH   = 2048,
   parameter bit REG_OUT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (REG_OUT) begin : g_reg
      logic [WIDTH-1:0] q_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q_r <= '0;
         else        q_r <= d_i;
      end
      assign q_o = q_r;
   end else begin : g_pass
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign q_o = d_i;
   end

endmodule

// File: rtl/sad_decoder.sv
module sad_decoder
   import sad_pkg::*;
#(
   parameter int IDX_W   = 11,
   parameter bit REG_OUT = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [IDX_W-1:0]    base_i,
   input  logic [IDX_W-1:0]    offset_i,
   output logic [2**IDX_W-1:0] wl_o
);

   localparam int LINES = 2 ** IDX_W;

   if (IDX_W < 1 || IDX_W > MAX_IDX_W) begin : g_bad_width
      $error("sad_decoder: IDX_W out of supported range");
   end

   logic [LINES-1:0] wl_comb;

   for (genvar r = 0; r < LINES; r++) begin : g_row
      sad_row #(.IDX_W(IDX_W), .ROW(r)) u_row (
         .base_i  (base_i),
         .offset_i(offset_i),
         .hit_o   (wl_comb[r])
      );
   end

   sad_out_stage #(.WIDTH(LINES), .REG_OUT(REG_OUT)) u_out (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (wl_comb),
      .q_o  (wl_o)
   );

   // reference sum used only by the checks below
   logic [IDX_W-1:0] sum_ref;
   assign sum_ref = base_i + offset_i;

   AST_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(wl_comb) == 1); // R2

   AST_SUM_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      wl_comb[sum_ref] == 1'b1); // R1

   AST_WRAP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (&base_i && offset_i == IDX_W'(1)) |-> wl_comb[0]); // R3

   if (REG_OUT) begin : g_reg_chk
      AST_REG_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> wl_o[$past(sum_ref)] == 1'b1); // R5

      AST_REG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> $countones(wl_o) == 1); // R2
   end else begin : g_comb_chk
      AST_PASS_SAME: assert property (@(posedge clk) disable iff (!rst_n)
         wl_o[sum_ref] == 1'b1); // R5
   end

endmodule

// File: tb/sad_decoder_tb.sv
`timescale 1ns/1ps
module sad_decoder_tb;

   localparam int IDX_W = 6;
   localparam int LINES = 2 ** IDX_W;
   localparam int MASK  = LINES - 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [IDX_W-1:0] base_i = '0;
   logic [IDX_W-1:0] offset_i = '0;
   logic [LINES-1:0] wl_o;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit done = 1'b0;
   bit mon_en = 1'b0;

   int    exp_q[$];
   string tag_q[$];

   always #2 clk = ~clk; // 250 MHz

   sad_decoder #(.IDX_W(IDX_W), .REG_OUT(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .base_i(base_i), .offset_i(offset_i), .wl_o(wl_o)
   );

   function automatic logic [LINES-1:0] onehot(input int idx);
      logic [LINES-1:0] v = '0;
      v[idx] = 1'b1;
      return v;
   endfunction

   task automatic check_vec(input string tag, input logic [LINES-1:0] act,
                            input logic [LINES-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: wl_o actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // driver: one operand pair per cycle, expected line pushed to the scoreboard
   task automatic drive(input int b, input int o, input string tag);
      @(negedge clk);
      base_i   = IDX_W'(b);
      offset_i = IDX_W'(o);
      exp_q.push_back((b + o) & MASK);
      tag_q.push_back(tag);
   endtask

   // monitor: result of the pair latched at this edge
   always @(posedge clk) begin
      if (mon_en && exp_q.size() > 0) begin
         int    e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         #1;
         check_vec(t, wl_o, onehot(e));
         checks++;
         if ($countones(wl_o) != 1) begin
            failures++;
            $display("FAIL R2: ones actual=%0d expected=1", $countones(wl_o));
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         failures++;
         checks++;
         $display("FAIL watchdog: cycles actual=%0d expected<=20000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      // R6: lines stay clear while reset is held, whatever the operands
      base_i = 6'd5; offset_i = 6'd9;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_vec("R6", wl_o, '0);
      base_i = 6'd63; offset_i = 6'd63;
      @(negedge clk);
      check_vec("R6", wl_o, '0);
      rst_n = 1'b1;
      @(negedge clk);

      // R5: inputs change mid-cycle, output holds until the next edge
      base_i = 6'd10; offset_i = 6'd20;
      @(posedge clk); #1;
      check_vec("R5", wl_o, onehot(30));
      @(negedge clk);
      base_i = 6'd1; offset_i = 6'd2;
      #1;
      check_vec("R5", wl_o, onehot(30));
      @(posedge clk); #1;
      check_vec("R5", wl_o, onehot(3));

      // R6: asynchronous clear in the middle of operation
      @(negedge clk);
      rst_n = 1'b0;
      #0.5;
      check_vec("R6", wl_o, '0);
      @(negedge clk);
      rst_n = 1'b1;

      mon_en = 1'b1;
      // R3: wrap past the top
      drive(63, 1, "R3");
      drive(63, 63, "R3");
      drive(32, 32, "R3");
      drive(1, 63, "R3");
      // R1 corners: zeros, ones, halves
      drive(0, 0, "R1");
      drive(63, 0, "R1");
      drive(0, 63, "R1");
      drive(21, 42, "R1");
      // R7: swapped operands
      drive(13, 50, "R7");
      drive(50, 13, "R7");
      drive(7, 60, "R7");
      drive(60, 7, "R7");
      // R4 and R1: every pair, every bit position
      for (int b = 0; b < LINES; b++)
         for (int o = 0; o < LINES; o++)
            drive(b, o, (b + o >= LINES) ? "R3" : "R4");
      @(negedge clk);
      @(negedge clk);
      mon_en = 1'b0;
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule